// File: doc/BRIEF.md
# Stopwatch Timer with Read-Cleared Interrupt Flags

This peripheral sits on the 4-bit register bus of a small microcontroller and measures elapsed time in hundredths and tenths of a second. It is driven by a one-cycle pulse at 256 Hz. A fixed phase-accumulator pattern turns every 256 of those pulses into exactly 100 counting steps. The count is held as two BCD digits. The hundredths digit carries into the tenths digit, and the tenths digit carries out once per second.

Each digit carry sets an interrupt flag. The hundredths carry gives the 10 Hz event and the tenths carry gives the 1 Hz event. A flag is set whether or not its mask bit is on, and a read of the flag register clears it. Each interrupt request output is the flag gated by its own mask bit.

A small two-state machine controls counting, with states STOPPED and RUNNING. The GO transition (control write with bit 1 = 1) leaves STOPPED, and the HALT transition (control write with bit 1 = 0) leaves RUNNING. Every control write also loads the run bit. To clear the count while the timer is running, software writes both bits as 1.

Software reads the low and high digits at separate addresses. A pair read across a carry can therefore be inconsistent, so a coherent read stops the timer for less than a quarter of a tick period, reads both digits and starts it again.

Top module: `stopwatch_timer`

## Requirements
- R1: After reset, every register reads 0, the machine is in STOPPED and both interrupt outputs are low.
- R2: In RUNNING, each 256 Hz tick adds 100 to a phase accumulator that is cleared by reset. When the sum reaches 256, 256 is subtracted and the count steps once, which gives exactly 100 steps per 256 ticks.
- R3: The low digit (address 0, bits 3:0) counts 0 to 9. A step taken at 9 returns it to 0, advances the high digit and sets flag bit 0 (the 10 Hz event), all at the same clock edge.
- R4: The high digit (address 1, bits 3:0) counts 0 to 9. A low-digit carry at 9 returns it to 0 and sets flag bit 1 (the 1 Hz event).
- R5: Flags are set by their carries whatever the mask bits hold.
- R6: A read of address 2 returns the flags in bits 1:0 and clears them at that clock edge. A carry in the same cycle wins, and its flag stays 1.
- R7: Writes to address 2 change nothing.
- R8: Writing control (address 3) with bit 0 = 1 clears both digits and the accumulator. That cycle's step is dropped. If the timer is running, counting continues from zero; if it is stopped, the count stays at zero.
- R9: Control bit 0 always reads 0. Writing 0 to it leaves the count unchanged.
- R10: Control bit 1 is the run bit and reads back its value. While it is 0, ticks are ignored and the count holds. Setting it to 1 resumes from the held count. The change takes effect from the cycle after the write.
- R11: The mask register (address 4) is readable and writable in bits 1:0. irq_tenth is high while flag 0 and mask 0 are both 1, and irq_second is high while flag 1 and mask 1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256 | input | 1 | One-cycle pulse at 256 Hz |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a flag read clears the flags |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, 0 when no read is active |
| irq_tenth | output | 1 | Masked 10 Hz interrupt request |
| irq_second | output | 1 | Masked 1 Hz interrupt request |

## Verification
The collision of interest is a flag-register read landing on the edge where a digit carry sets that flag. If it is resolved wrongly, an interrupt is lost. The bench forces this case by reading the flag register on every cycle of a long stretch of ticks, so some of those reads fall on carry edges. A second collision is a count clear written during a tick cycle. The bench provokes it by issuing clears on tick cycles while the timer runs. Both cases are judged by a behavioural model that gives the carry priority over the clearing read and gives the clear priority over the step. Every read and both interrupt outputs are compared with that model.

// File: rtl/sw_pkg.sv
package sw_pkg;

    // register addresses
    localparam int SW_ADDR_LO    = 0;
    localparam int SW_ADDR_HI    = 1;
    localparam int SW_ADDR_FLAGS = 2;
    localparam int SW_ADDR_CTRL  = 3;
    localparam int SW_ADDR_MASK  = 4;

    // control bit positions
    localparam int SW_CTRL_CLR = 0;
    localparam int SW_CTRL_RUN = 1;

    typedef enum logic {
        SW_STOPPED = 1'b0,
        SW_RUNNING = 1'b1
    } sw_state_e;

endpackage

// File: rtl/sw_prescale.sv
module sw_prescale #(
    parameter int NUM = 100,
    parameter int DEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic step
);
    localparam int ACC_W = $clog2(DEN) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             wrap;

    always_comb begin
        acc_sum = acc_q + ACC_W'(NUM);
        wrap    = (acc_sum >= ACC_W'(DEN));
        step    = en && tick && !clr && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en && tick) begin
            acc_q <= wrap ? (acc_sum - ACC_W'(DEN)) : acc_sum;
        end
    end

endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
    parameter int DIG_W = 4,
    parameter int MAXV  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [DIG_W-1:0] value,
    output logic             carry
);
    logic [DIG_W-1:0] val_q;
    logic             at_top;

    always_comb begin
        at_top = (val_q == DIG_W'(MAXV));
        carry  = inc && at_top;
        value  = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr) begin
            val_q <= '0;
        end else if (inc) begin
            val_q <= at_top ? '0 : val_q + 1'b1;
        end
    end

endmodule

// File: rtl/sw_irq_flags.sv
module sw_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         rd_clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);
    logic [N-1:0] flag_q;

    // a set event in the same cycle as a clearing read wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= set_ev | (flag_q & ~{N{rd_clr}});
        end
    end

    always_comb begin
        flags = flag_q;
        irq   = flag_q & mask;
    end

endmodule

// File: rtl/stopwatch_timer.sv
module stopwatch_timer
    import sw_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 4,
    parameter int DIG_W    = 4,
    parameter int NDIG     = 2,
    parameter int TICK_NUM = 100,
    parameter int TICK_DEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_256,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_tenth,
    output logic              irq_second
);
    sw_state_e        state_q, state_d;
    logic             count_en;
    logic             run_bit;
    logic             wr_ctrl, wr_mask, rd_flags, clr;
    logic             step;
    logic [NDIG:0]    inc_chain;
    logic [DIG_W-1:0] dig_val [NDIG];
    logic [NDIG-1:0]  flag_q, irq_v, mask_q;

    // bus decode
    always_comb begin
        wr_ctrl  = bus_wr && (int'(bus_addr) == SW_ADDR_CTRL);
        wr_mask  = bus_wr && (int'(bus_addr) == SW_ADDR_MASK);
        rd_flags = bus_rd && (int'(bus_addr) == SW_ADDR_FLAGS);
        clr      = wr_ctrl && bus_wdata[SW_CTRL_CLR];
    end

    // run/stop state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_STOPPED;
        else        state_q <= state_d;
    end

    // transitions: GO and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_STOPPED: if (wr_ctrl && bus_wdata[SW_CTRL_RUN])  state_d = SW_RUNNING;
            SW_RUNNING: if (wr_ctrl && !bus_wdata[SW_CTRL_RUN]) state_d = SW_STOPPED;
            default:    state_d = SW_STOPPED;
        endcase
    end

    // state outputs
    always_comb begin
        count_en = 1'b0;
        run_bit  = 1'b0;
        unique case (state_q)
            SW_STOPPED: begin count_en = 1'b0; run_bit = 1'b0; end
            SW_RUNNING: begin count_en = 1'b1; run_bit = 1'b1; end
            default:    begin count_en = 1'b0; run_bit = 1'b0; end
        endcase
    end

    sw_prescale #(.NUM(TICK_NUM), .DEN(TICK_DEN)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (count_en),
        .tick (tick_256),
        .clr  (clr),
        .step (step)
    );

    assign inc_chain[0] = step;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        sw_bcd_digit #(.DIG_W(DIG_W), .MAXV(9)) u_dig (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .inc  (inc_chain[g]),
            .value(dig_val[g]),
            .carry(inc_chain[g+1])
        );
    end

    sw_irq_flags #(.N(NDIG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(inc_chain[NDIG:1]),
        .rd_clr(rd_flags),
        .mask  (mask_q),
        .flags (flag_q),
        .irq   (irq_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata[NDIG-1:0];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (int'(bus_addr))
                SW_ADDR_LO:    bus_rdata = DATA_W'(dig_val[0]);
                SW_ADDR_HI:    bus_rdata = DATA_W'(dig_val[NDIG-1]);
                SW_ADDR_FLAGS: bus_rdata = DATA_W'(flag_q);
                SW_ADDR_CTRL:  bus_rdata = DATA_W'({run_bit, 1'b0});
                SW_ADDR_MASK:  bus_rdata = DATA_W'(mask_q);
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign irq_tenth  = irq_v[0];
    assign irq_second = irq_v[NDIG-1];

endmodule

// File: rtl/sw_checker.sv
module sw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [3:0] bus_wdata,
    input logic [3:0] bus_rdata,
    input logic [3:0] lo,
    input logic [3:0] hi,
    input logic [1:0] flags,
    input logic       carry_lo,
    input logic       running,
    input logic       irq_tenth,
    input logic       irq_second
);
    // R3
    lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n) lo <= 4'd9);

    // R4
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hi <= 4'd9);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_lo |=> flags[0]);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && !carry_lo) |=> !flags[0]);

    // R8
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3 && bus_wdata[0]) |=> (lo == 4'd0 && hi == 4'd0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(bus_wr && bus_addr == 3'd3 && bus_wdata[0])) |=> ($stable(lo) && $stable(hi)));

    // R9
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd3) |-> !bus_rdata[0]);

    // R11
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tenth |-> flags[0]) and (irq_second |-> flags[1]));

endmodule

bind stopwatch_timer sw_checker u_sw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lo        (dig_val[0]),
    .hi        (dig_val[1]),
    .flags     (flag_q),
    .carry_lo  (inc_chain[1]),
    .running   (count_en),
    .irq_tenth (irq_tenth),
    .irq_second(irq_second)
);

// File: tb/test_stopwatch_timer.sv
module test_stopwatch_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       irq_tenth, irq_second;

    int n_checks = 0;
    int n_errors = 0;

    // behavioural reference state
    int  m_acc = 0, m_lo = 0, m_hi = 0;
    bit  m_f10 = 0, m_f1 = 0, m_run = 0, m_k10 = 0, m_k1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopwatch_timer i_stopwatch_timer (
        .clk(clk), .rst_n(rst_n), .tick_256(tick_256),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tenth(irq_tenth), .irq_second(irq_second)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return (int'(m_f1) << 1) | int'(m_f10);
            3: return int'(m_run) << 1;
            4: return (int'(m_k1) << 1) | int'(m_k10);
            default: return 0;
        endcase
    endfunction

    // one bus cycle: compare irqs, drive, compare read data, advance the model
    task automatic cyc(input int a, input bit rd, input bit wr, input int wd,
                       input bit tk, input string tag);
        bit clr, inc, c10, c1;
        @(negedge clk);
        check("R11 irq_tenth", int'(irq_tenth), int'(m_f10 && m_k10));
        check("R11 irq_second", int'(irq_second), int'(m_f1 && m_k1));
        bus_addr = 3'(a); bus_rd = rd; bus_wr = wr; bus_wdata = 4'(wd); tick_256 = tk;
        #1;
        if (rd) check(tag, int'(bus_rdata), model_read(a));
        @(posedge clk);
        clr = wr && (a == 3) && wd[0];
        inc = 0; c10 = 0; c1 = 0;
        if (m_run && tk && !clr) begin
            m_acc += 100;
            if (m_acc >= 256) begin m_acc -= 256; inc = 1; end
        end
        if (clr) begin m_lo = 0; m_hi = 0; m_acc = 0; end
        if (inc) begin
            if (m_lo == 9) begin
                m_lo = 0; c10 = 1;
                if (m_hi == 9) begin m_hi = 0; c1 = 1; end
                else m_hi++;
            end else m_lo++;
        end
        if (rd && a == 2) begin m_f10 = c10; m_f1 = c1; end
        else begin m_f10 = m_f10 | c10; m_f1 = m_f1 | c1; end
        if (wr && a == 3) m_run = wd[1];
        if (wr && a == 4) begin m_k10 = wd[0]; m_k1 = wd[1]; end
    endtask

    task automatic rd(input int a, input string tag);
        cyc(a, 1, 0, 0, 0, tag);
    endtask

    task automatic wr(input int a, input int d);
        cyc(a, 0, 1, d, 0, "wr");
    endtask

    // ticks on alternate cycles, reading the digits along the way
    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(0, 1, 0, 0, 1, tag);
            cyc(1, 1, 0, 0, 0, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 6; a++) rd(a, "R1 reset value");

        // R10: start, count, read run bit
        wr(3, 2);
        rd(3, "R10 run bit readback");
        ticks(40, "R2 prescaled count");
        // R10: stop holds, resume continues
        wr(3, 0);
        rd(3, "R10 run bit cleared");
        ticks(20, "R10 hold while stopped");
        wr(3, 2);
        ticks(20, "R10 resume");

        // R3 R4 R5: flags with masks off
        ticks(60, "R3 low digit carry");
        rd(2, "R5 flags set with mask off");
        rd(2, "R6 flags cleared by read");
        ticks(260, "R4 high digit carry");
        rd(2, "R4 one-second flag");

        // R7: writes to flag register ignored
        wr(2, 0);
        rd(2, "R7 flag write 0 ignored");
        wr(2, 3);
        rd(2, "R7 flag write 3 ignored");

        // R11: masks
        wr(4, 3);
        rd(4, "R11 mask readback");
        ticks(270, "R11 masked irq run");
        rd(2, "R11 flags");
        wr(4, 1);
        ticks(30, "R11 partial mask");

        // R8: clear while running, including on tick cycles
        wr(3, 3);
        rd(0, "R8 clear running lo");
        rd(1, "R8 clear running hi");
        for (int i = 0; i < 12; i++) begin
            cyc(3, 0, 1, 3, 1, "R8");
            ticks(5, "R8 continue after clear");
        end
        // R8: clear while stopped stays at zero
        wr(3, 0);
        wr(3, 1);
        ticks(10, "R8 clear stopped holds zero");

        // R9: writing 0 to clear bit leaves count
        wr(3, 2);
        ticks(15, "R9 count");
        wr(3, 2);
        rd(0, "R9 no clear lo");
        rd(3, "R9 clear bit reads 0");

        // R2: exactly 100 steps per 256 ticks from a clear
        wr(3, 3);
        rd(2, "R2 flag drain");
        for (int i = 0; i < 256; i++) begin
            cyc(5, 0, 0, 0, 1, "R2");
        end
        rd(0, "R2 lo after 256 ticks");
        rd(1, "R2 hi after 256 ticks");
        rd(2, "R2 one-second flag after 256 ticks");

        // R6: read on every cycle so reads collide with carries
        for (int i = 0; i < 700; i++) begin
            cyc(2, 1, 0, 0, 1, "R6 read vs set collision");
        end
        rd(2, "R6 final flags");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule